// File: doc/BRIEF.md
# Ternary Nanomagnet Cell Evaluator

This block is a clocked, synthesizable model of one cell in a grid of magnetic cellular-automaton elements. The cell watches four neighbours (north, south, east, west). Each neighbour carries one of three values: logic 0, logic 1 or a null (metastable) value. The cell forms a signed magnetization sum from these inputs. Vertical neighbours couple without inversion and horizontal neighbours couple with inversion. The cell then turns the sign of the sum back into a ternary value. One clock cycle stands for one nanomagnet switching delay. A chain of cells therefore carries a value one grid position per cycle.

A two-bit field-control input selects the phase. In the erase phase the external field forces the cell to null. In the evaluate phase a null cell settles to a value and then keeps it. In the freeze phase the cell keeps whatever it holds. A grid position that has no neighbour on one side ties that input to the null code. Cells in the same clock zone share one phase input.

Top module: `nm_cell`

## Requirements
- R1: While rst_n is low at a rising clock edge, cell_q becomes null (2'b00) after that edge, whatever the other inputs are.
- R2: A phase code of 2'b00 (erase), or the unused code 2'b11, makes cell_q null after the next edge, whatever the neighbour values are.
- R3: Neighbour codes map to magnetization as follows: 2'b11 (logic 1) gives +1, 2'b10 (logic 0) gives -1, and 2'b00 (null) gives 0. The sum is M = n + s - e - w, so a value that enters from east or west is inverted.
- R4: In the evaluate phase (code 2'b01), a null cell takes 2'b11 when M > 0, 2'b10 when M < 0, and stays 2'b00 when M = 0. The output never shows code 2'b01.
- R5: An evaluation result appears on cell_q exactly one clock edge after the inputs that produced it are applied.
- R6: In the evaluate phase, a cell whose output is already 2'b10 or 2'b11 keeps that value, even when its neighbours would now give a different one.
- R7: In the freeze phase (code 2'b10), cell_q does not change, and this includes a null output.
- R8: A neighbour input carrying the illegal code 2'b01 counts as null, with magnetization 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one switching step |
| rst_n | input | 1 | Synchronous active-low reset to null |
| phase | input | 2 | Field control: 00 erase, 01 evaluate, 10 freeze, 11 erase |
| nbr_n | input | 2 | North neighbour value (non-inverting) |
| nbr_s | input | 2 | South neighbour value (non-inverting) |
| nbr_e | input | 2 | East neighbour value (inverting) |
| nbr_w | input | 2 | West neighbour value (inverting) |
| cell_q | output | 2 | Cell value: 00 null, 10 logic 0, 11 logic 1 |

## Verification
The hardest case to reach is the latch in the evaluate phase. The cell must already hold a value, and the neighbours must then change to a pattern that would settle it the other way. The stimulus first settles the cell from a single north input. It then stays in the evaluate phase, applies the opposite pattern and checks that the old value stays. A separate sweep erases the cell before each of the 256 neighbour-code combinations, which include the illegal code. Each combination then gets a single evaluate step, so every sum from -4 to +4 and the zero-sum null case are each checked from a known null start.

// File: rtl/nmc_pkg.sv
`timescale 1ns/100ps
package nmc_pkg;
    localparam int N_DIR  = 4;
    localparam int N_VERT = 2;
    localparam int MAG_W  = $clog2(N_DIR + 1) + 1;

    typedef logic [1:0] tern_t;
    localparam tern_t T_NULL = 2'b00;
    localparam tern_t T_ZERO = 2'b10;
    localparam tern_t T_ONE  = 2'b11;

    typedef enum logic [1:0] {
        PH_ERASE  = 2'b00,
        PH_EVAL   = 2'b01,
        PH_FREEZE = 2'b10,
        PH_SPARE  = 2'b11
    } phase_e;

    typedef struct packed {
        tern_t val;
    } cell_st_t;
endpackage

// File: rtl/nmc_mag.sv
`timescale 1ns/100ps
module nmc_mag #(
    parameter int MAG_W = 4
) (
    input  logic [1:0]              tern,
    output logic signed [MAG_W-1:0] mag
);
    always_comb begin
        case (tern)
            2'b11:   mag = MAG_W'(signed'(1));
            2'b10:   mag = -MAG_W'(signed'(1));
            default: mag = '0;
        endcase
    end
endmodule

// File: rtl/nmc_resolve.sv
`timescale 1ns/100ps
module nmc_resolve #(
    parameter int MAG_W = 4
) (
    input  logic signed [MAG_W-1:0] sum,
    output logic [1:0]              tern
);
    always_comb begin
        if (sum > 0)
            tern = 2'b11;
        else if (sum < 0)
            tern = 2'b10;
        else
            tern = 2'b00;
    end
endmodule

// File: rtl/nm_cell.sv
`timescale 1ns/100ps
module nm_cell
    import nmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] phase,
    input  logic [1:0] nbr_n,
    input  logic [1:0] nbr_s,
    input  logic [1:0] nbr_e,
    input  logic [1:0] nbr_w,
    output logic [1:0] cell_q
);
    tern_t                   nbr_a [N_DIR];
    logic signed [MAG_W-1:0] mag_a [N_DIR];
    logic signed [MAG_W-1:0] sum_m;
    tern_t                   res_t;
    phase_e                  ph;
    cell_st_t                st_d, st_q;

    assign nbr_a[0] = nbr_n;
    assign nbr_a[1] = nbr_s;
    assign nbr_a[2] = nbr_e;
    assign nbr_a[3] = nbr_w;
    assign ph       = phase_e'(phase);

    for (genvar gi = 0; gi < N_DIR; gi++) begin : g_dir
        nmc_mag #(.MAG_W(MAG_W)) u_mag (
            .tern (nbr_a[gi]),
            .mag  (mag_a[gi])
        );
    end

    always_comb begin
        sum_m = '0;
        for (int i = 0; i < N_DIR; i++) begin
            if (i < N_VERT)
                sum_m = sum_m + mag_a[i];
            else
                sum_m = sum_m - mag_a[i];
        end
    end

    nmc_resolve #(.MAG_W(MAG_W)) u_res (
        .sum  (sum_m),
        .tern (res_t)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.val = T_NULL;
        end else begin
            case (ph)
                PH_EVAL:   if (st_q.val == T_NULL) st_d.val = res_t;
                PH_FREEZE: st_d.val = st_q.val;
                default:   st_d.val = T_NULL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cell_q = st_q.val;

    // R1
    rst_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cell_q == T_NULL);

    // R2
    erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00 || phase == 2'b11) |=> cell_q == T_NULL);

    // R4
    legal_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cell_q != 2'b01);

    // R4
    pos_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b01 && cell_q == T_NULL && sum_m > 0) |=> cell_q == T_ONE);

    // R6
    latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b01 && cell_q != T_NULL) |=> $stable(cell_q));

    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 2'b10 |=> $stable(cell_q));
endmodule

// File: tb/nm_cell_test.sv
`timescale 1ns/100ps
module nm_cell_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] phase = 2'b00;
    logic [1:0] nbr_n = 2'b00, nbr_s = 2'b00, nbr_e = 2'b00, nbr_w = 2'b00;
    logic [1:0] cell_q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [1:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    nm_cell uut (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .nbr_n(nbr_n), .nbr_s(nbr_s), .nbr_e(nbr_e), .nbr_w(nbr_w),
        .cell_q(cell_q)
    );

    function automatic int magof(logic [1:0] t);
        if (t == 2'b11) return 1;
        if (t == 2'b10) return -1;
        return 0;
    endfunction

    function automatic logic [1:0] settle(logic [1:0] n, logic [1:0] s,
                                          logic [1:0] e, logic [1:0] w);
        int m;
        m = magof(n) + magof(s) - magof(e) - magof(w);
        if (m > 0) return 2'b11;
        if (m < 0) return 2'b10;
        return 2'b00;
    endfunction

    task automatic apply(input logic r, input logic [1:0] ph,
                         input logic [1:0] n, input logic [1:0] s,
                         input logic [1:0] e, input logic [1:0] w,
                         input logic [1:0] exp, input string tag);
        @(negedge clk);
        rst_n = r; phase = ph;
        nbr_n = n; nbr_s = s; nbr_e = e; nbr_w = w;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (cell_q !== e) begin
                    bad++;
                    $display("FAIL %s: cell_q=%b expected=%b", t, cell_q, e);
                end
            end
        end
    end

    initial begin : driver
        // reset state, strong inputs ignored
        apply(0, 2'b01, 2'b11, 2'b11, 2'b10, 2'b10, 2'b00, "R1 reset");
        apply(1, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, "R2 erase");
        // settle from north only; one edge after apply
        apply(1, 2'b01, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, "R5 R3 north one");
        apply(1, 2'b01, 2'b10, 2'b10, 2'b11, 2'b11, 2'b11, "R6 latch keeps one");
        apply(1, 2'b10, 2'b10, 2'b00, 2'b00, 2'b00, 2'b11, "R7 freeze keeps one");
        apply(1, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, "R2 erase after value");
        apply(1, 2'b10, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, "R7 freeze keeps null");
        apply(1, 2'b01, 2'b00, 2'b00, 2'b11, 2'b00, 2'b10, "R3 east inverts");
        apply(1, 2'b01, 2'b11, 2'b11, 2'b00, 2'b00, 2'b10, "R6 latch keeps zero");
        apply(1, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, "R2 erase");
        apply(1, 2'b01, 2'b00, 2'b00, 2'b00, 2'b10, 2'b11, "R3 west inverts");
        apply(1, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, "R2 spare code erases");
        apply(1, 2'b01, 2'b11, 2'b00, 2'b11, 2'b00, 2'b00, "R4 zero sum null");
        apply(1, 2'b01, 2'b00, 2'b10, 2'b00, 2'b00, 2'b10, "R4 negative after null");
        apply(0, 2'b01, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, "R1 reset mid run");
        apply(1, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b00, "R8 illegal as null");
        apply(1, 2'b01, 2'b01, 2'b00, 2'b10, 2'b01, 2'b11, "R8 illegal plus east zero");
        apply(1, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, "R2 erase");
        apply(1, 2'b01, 2'b10, 2'b10, 2'b11, 2'b11, 2'b10, "R3 full negative sum");
        // sweep every neighbour code combination from a null start
        for (int k = 0; k < 256; k++) begin
            logic [1:0] n, s, e, w;
            n = k[7:6]; s = k[5:4]; e = k[3:2]; w = k[1:0];
            apply(1, 2'b00, n, s, e, w, 2'b00, "R2 sweep erase");
            apply(1, 2'b01, n, s, e, w, settle(n, s, e, w), "R3 R4 R8 sweep");
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: cell_q=%b expected=finished run", cell_q);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule